// File: doc/BRIEF.md
# Triggered Dual-Channel Capture Controller

This block records two signed 14-bit converter sample streams into an on-chip sample buffer. Both channels are stored side by side, one sample per clock per channel. A host programs it through a small word-wide register port. It sets a trace length and chooses whether capture begins at once or waits for a trigger. It then issues start, stop or reset commands, and polls a status word until the trace is complete. Stored samples come back through a separate address-driven read port. Each channel returns its sample sign-extended to 16 bits.

The register port also holds three constant identification words and a loopback pair. The host uses them to confirm that the link works before it relies on captured data.

Register offsets on `reg_addr`:

| Offset | Access | Contents |
|---|---|---|
| 0 | read | 0xDEADBEEF |
| 1 | read | 0xABADCAFE |
| 2 | read | 0xBEEFBEEF |
| 3 | write | loopback input |
| 4 | read | loopback output |
| 5 | read/write | length |
| 6 | read/write | arm flag, bit 0 |
| 7 | write | command, bits [1:0] |
| 8 | read | status |
| 9 | read | sample count |

Top module: `trace_capture`

## Requirements
- R1: After reset the controller is idle. The status word (offset 8) and the sample count (offset 9) both read 0.
- R2: Offsets 0, 1 and 2 always read 0xDEADBEEF, 0xABADCAFE and 0xBEEFBEEF.
- R3: A word written to offset 3 reads back unchanged from offset 4. Offset 4 reads 0 after reset.
- R4: Command value 1 written to offset 7 starts a capture when the arm flag (offset 6, bit 0) is 0 and the controller is idle or done. The samples present at the clock edges that follow the edge registering the command are stored at addresses 0, 1, 2 and so on, in that order.
- R5: The read port returns, one clock after `rd_addr` is presented, the stored sample of each channel. Each is the 14-bit input sign-extended to 16 bits.
- R6: A capture stores exactly min(length, DEPTH) samples and then enters done. The length is written at offset 5. A length of 0 enters done at once with a count of 0.
- R7: With the arm flag set, start enters the armed state and stores nothing. A one-cycle pulse on `trig` while armed begins recording. The first sample stored is the one present at the edge after the trigger edge.
- R8: `trig` has no effect unless the controller is armed.
- R9: Command value 2 (stop) while armed or recording enters done and keeps the count reached. The sample at the stop edge is not stored.
- R10: Command value 3 (reset) returns the controller to idle from any state and clears the count to 0.
- R11: A start while armed or recording is ignored. A start from done clears the count and begins a new capture.
- R12: Status bit 0 is busy (armed or recording), bit 1 is armed and bit 2 is done. All other bits read 0. The offset 9 word holds the number of samples stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | RA_W | Register offset for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| adc_a | input | ADC_W | Channel A sample, signed |
| adc_b | input | ADC_W | Channel B sample, signed |
| trig | input | 1 | One-cycle trigger pulse |
| rd_addr | input | log2(DEPTH) | Sample buffer read address |
| rd_a | output | SMP_W | Channel A stored sample, one cycle after address |
| rd_b | output | SMP_W | Channel B stored sample, one cycle after address |

## Verification
The bench sweeps trace lengths of 1, 5, 17, DEPTH, above DEPTH and 0. An off-by-one in the stop compare would show as a count one too high or too low. A missing clamp would run past the buffer. A zero-length trace that recorded would hang busy.

It checks the first and last stored samples against a ramp whose value at each edge is known. A design that stored the sample on the command or trigger edge would show a one-step shift. Dropping the sign extension would show as a wrong upper byte on the negative channel.

Directed cases cover the following:
- a trigger pulse while idle or done, which must not start anything;
- stop from armed and from recording, where losing or advancing the partial count is caught;
- a second start during recording, which must not restart the trace;
- the reset command in the middle of a capture.

// File: rtl/tc_pkg.sv
package tc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_REC   = 2'd2,
    ST_DONE  = 2'd3
  } tc_state_e;

  localparam logic [1:0] CMD_START = 2'd1;
  localparam logic [1:0] CMD_STOP  = 2'd2;
  localparam logic [1:0] CMD_RESET = 2'd3;

  localparam logic [3:0] OFF_ID0      = 4'd0;
  localparam logic [3:0] OFF_ID1      = 4'd1;
  localparam logic [3:0] OFF_ID2      = 4'd2;
  localparam logic [3:0] OFF_LOOP_IN  = 4'd3;
  localparam logic [3:0] OFF_LOOP_OUT = 4'd4;
  localparam logic [3:0] OFF_LEN      = 4'd5;
  localparam logic [3:0] OFF_ARM      = 4'd6;
  localparam logic [3:0] OFF_CMD      = 4'd7;
  localparam logic [3:0] OFF_STAT     = 4'd8;
  localparam logic [3:0] OFF_CNT      = 4'd9;

  localparam logic [31:0] ID_WORD0 = 32'hDEAD_BEEF;
  localparam logic [31:0] ID_WORD1 = 32'hABAD_CAFE;
  localparam logic [31:0] ID_WORD2 = 32'hBEEF_BEEF;

endpackage

// File: rtl/tc_regs.sv
module tc_regs
  import tc_pkg::*;
#(
  parameter int RA_W  = 4,
  parameter int LEN_W = 16,
  parameter int CW    = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [RA_W-1:0]  addr,
  input  logic [31:0]      wdata,
  input  tc_state_e        state,
  input  logic [CW-1:0]    count,
  output logic [31:0]      rdata,
  output logic [LEN_W-1:0] len_q,
  output logic             arm_q,
  output logic             cmd_start,
  output logic             cmd_stop,
  output logic             cmd_reset
);

  logic [31:0] loop_q;
  logic        loop_en;
  logic        len_en;
  logic        arm_en;
  logic        cmd_hit;
  logic        st_busy;
  logic        st_armed;
  logic        st_done;

  assign loop_en = we && (addr == RA_W'(OFF_LOOP_IN));
  assign len_en  = we && (addr == RA_W'(OFF_LEN));
  assign arm_en  = we && (addr == RA_W'(OFF_ARM));
  assign cmd_hit = we && (addr == RA_W'(OFF_CMD));

  assign cmd_start = cmd_hit && (wdata[1:0] == CMD_START);
  assign cmd_stop  = cmd_hit && (wdata[1:0] == CMD_STOP);
  assign cmd_reset = cmd_hit && (wdata[1:0] == CMD_RESET);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loop_q <= '0;
      len_q  <= '0;
      arm_q  <= 1'b0;
    end else begin
      if (loop_en) loop_q <= wdata;
      if (len_en)  len_q  <= wdata[LEN_W-1:0];
      if (arm_en)  arm_q  <= wdata[0];
    end
  end

  assign st_armed = (state == ST_ARMED);
  assign st_busy  = st_armed || (state == ST_REC);
  assign st_done  = (state == ST_DONE);

  always_comb begin
    rdata = '0;
    case (addr)
      RA_W'(OFF_ID0):      rdata = ID_WORD0;
      RA_W'(OFF_ID1):      rdata = ID_WORD1;
      RA_W'(OFF_ID2):      rdata = ID_WORD2;
      RA_W'(OFF_LOOP_OUT): rdata = loop_q;
      RA_W'(OFF_LEN):      rdata = 32'(len_q);
      RA_W'(OFF_ARM):      rdata = {31'd0, arm_q};
      RA_W'(OFF_STAT):     rdata = {29'd0, st_done, st_armed, st_busy};
      RA_W'(OFF_CNT):      rdata = 32'(count);
      default:             rdata = '0;
    endcase
  end

endmodule

// File: rtl/tc_fsm.sv
module tc_fsm
  import tc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cmd_start,
  input  logic      cmd_stop,
  input  logic      cmd_reset,
  input  logic      trig,
  input  logic      arm,
  input  logic      last,
  input  logic      len_zero,
  output tc_state_e state,
  output logic      wr_en,
  output logic      clr
);

  tc_state_e state_d;

  always_comb begin
    state_d = state;
    wr_en   = 1'b0;
    clr     = 1'b0;
    if (cmd_reset) begin
      state_d = ST_IDLE;
      clr     = 1'b1;
    end else begin
      case (state)
        ST_IDLE, ST_DONE: begin
          if (cmd_start) begin
            clr = 1'b1;
            if (arm)           state_d = ST_ARMED;
            else if (len_zero) state_d = ST_DONE;
            else               state_d = ST_REC;
          end
        end
        ST_ARMED: begin
          if (cmd_stop)  state_d = ST_DONE;
          else if (trig) state_d = len_zero ? ST_DONE : ST_REC;
        end
        ST_REC: begin
          if (cmd_stop) begin
            state_d = ST_DONE;
          end else begin
            wr_en = 1'b1;
            if (last) state_d = ST_DONE;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_d;
  end

endmodule

// File: rtl/tc_addr.sv
module tc_addr #(
  parameter int DEPTH = 64,
  parameter int AW    = 6,
  parameter int CW    = 7,
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  input  logic [LEN_W-1:0] len,
  output logic [CW-1:0]    count,
  output logic [CW-1:0]    eff_len,
  output logic [AW-1:0]    waddr,
  output logic             last,
  output logic             len_zero
);

  logic [CW-1:0] count_d;
  logic [CW-1:0] count_p1;

  always_comb begin
    if (len > LEN_W'(DEPTH)) eff_len = CW'(DEPTH);
    else                     eff_len = CW'(len);
  end

  assign len_zero = (eff_len == '0);
  assign count_p1 = count + 1'b1;
  assign last     = (count_p1 >= eff_len);
  assign waddr    = count[AW-1:0];

  always_comb begin
    count_d = count;
    if (clr)      count_d = '0;
    else if (inc) count_d = count_p1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= count_d;
  end

endmodule

// File: rtl/tc_buf.sv
module tc_buf #(
  parameter int DEPTH = 64,
  parameter int AW    = 6,
  parameter int NCH   = 2,
  parameter int ADC_W = 14,
  parameter int SMP_W = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        we,
  input  logic [AW-1:0]               waddr,
  input  logic [NCH-1:0][ADC_W-1:0]   din,
  input  logic [AW-1:0]               raddr,
  output logic [NCH-1:0][SMP_W-1:0]   dout
);

  localparam int EXT_W = SMP_W - ADC_W;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic [SMP_W-1:0] mem [DEPTH];
    logic [SMP_W-1:0] wval;
    logic [SMP_W-1:0] rd_q;

    assign wval = {{EXT_W{din[ch][ADC_W-1]}}, din[ch]};

    always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wval;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rd_q <= '0;
      else        rd_q <= mem[raddr];
    end

    assign dout[ch] = rd_q;
  end

endmodule

// File: rtl/trace_capture.sv
module trace_capture
  import tc_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int ADC_W = 14,
  parameter int SMP_W = 16,
  parameter int LEN_W = 16,
  parameter int RA_W  = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     reg_we,
  input  logic [RA_W-1:0]          reg_addr,
  input  logic [31:0]              reg_wdata,
  output logic [31:0]              reg_rdata,
  input  logic [ADC_W-1:0]         adc_a,
  input  logic [ADC_W-1:0]         adc_b,
  input  logic                     trig,
  input  logic [$clog2(DEPTH)-1:0] rd_addr,
  output logic [SMP_W-1:0]         rd_a,
  output logic [SMP_W-1:0]         rd_b
);

  localparam int AW  = $clog2(DEPTH);
  localparam int CW  = AW + 1;
  localparam int NCH = 2;

  logic [1:0]                rst_pipe;
  logic                      rst_q;
  tc_state_e                 state;
  logic [CW-1:0]             count;
  logic [CW-1:0]             eff_len;
  logic [AW-1:0]             waddr;
  logic [LEN_W-1:0]          len_q;
  logic                      arm_q;
  logic                      cmd_start;
  logic                      cmd_stop;
  logic                      cmd_reset;
  logic                      last;
  logic                      len_zero;
  logic                      wr_en;
  logic                      clr;
  logic [NCH-1:0][ADC_W-1:0] din;
  logic [NCH-1:0][SMP_W-1:0] dout;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q = rst_pipe[1];

  assign din  = {adc_b, adc_a};
  assign rd_a = dout[0];
  assign rd_b = dout[1];

  tc_regs #(.RA_W(RA_W), .LEN_W(LEN_W), .CW(CW)) u_regs (
    .clk(clk), .rst_n(rst_q), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .state(state), .count(count), .rdata(reg_rdata),
    .len_q(len_q), .arm_q(arm_q), .cmd_start(cmd_start),
    .cmd_stop(cmd_stop), .cmd_reset(cmd_reset)
  );

  tc_fsm u_fsm (
    .clk(clk), .rst_n(rst_q), .cmd_start(cmd_start), .cmd_stop(cmd_stop),
    .cmd_reset(cmd_reset), .trig(trig), .arm(arm_q), .last(last),
    .len_zero(len_zero), .state(state), .wr_en(wr_en), .clr(clr)
  );

  tc_addr #(.DEPTH(DEPTH), .AW(AW), .CW(CW), .LEN_W(LEN_W)) u_addr (
    .clk(clk), .rst_n(rst_q), .clr(clr), .inc(wr_en), .len(len_q),
    .count(count), .eff_len(eff_len), .waddr(waddr), .last(last),
    .len_zero(len_zero)
  );

  tc_buf #(.DEPTH(DEPTH), .AW(AW), .NCH(NCH), .ADC_W(ADC_W), .SMP_W(SMP_W)) u_buf (
    .clk(clk), .rst_n(rst_q), .we(wr_en), .waddr(waddr), .din(din),
    .raddr(rd_addr), .dout(dout)
  );

endmodule

// File: rtl/tc_chk.sv
module tc_chk
  import tc_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int CW    = 7
) (
  input logic          clk,
  input logic          rst_n,
  input tc_state_e     state,
  input logic [CW-1:0] count,
  input logic [CW-1:0] eff_len,
  input logic          wr_en,
  input logic          trig,
  input logic          cmd_start,
  input logic          cmd_stop,
  input logic          cmd_reset
);

  a_r4_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (count == CW'($past(count) + 1'b1)));

  a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  a_r6_done_at_len: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DONE && $past(state) == ST_REC && !$past(cmd_stop))
      |-> (count == $past(eff_len)));

  a_r7_armed_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ARMED) |-> !wr_en);

  a_r8_trig_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_IDLE || state == ST_DONE) && trig && !cmd_start && !cmd_reset)
      |=> $stable(state));

  a_r9_stop_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_stop && (state == ST_ARMED || state == ST_REC))
      |=> (state == ST_DONE && $stable(count)));

  a_r10_reset_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_reset |=> (state == ST_IDLE && count == '0));

endmodule

bind trace_capture tc_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_q), .state(state), .count(count), .eff_len(eff_len),
  .wr_en(wr_en), .trig(trig), .cmd_start(cmd_start), .cmd_stop(cmd_stop),
  .cmd_reset(cmd_reset)
);

// File: tb/tb_trace_capture.sv
`timescale 1ns/1ps
module tb_trace_capture;

  localparam int DEPTH = 64;
  localparam int AW    = $clog2(DEPTH);

  localparam logic [31:0] VLEN [6] = '{32'd1, 32'd5, 32'd17, 32'd64, 32'd100, 32'd0};
  localparam logic [31:0] VEXP [6] = '{32'd1, 32'd5, 32'd17, 32'd64, 32'd64,  32'd0};

  logic          clk;
  logic          rst_n;
  logic          reg_we;
  logic [3:0]    reg_addr;
  logic [31:0]   reg_wdata;
  logic [31:0]   reg_rdata;
  logic [13:0]   adc_a;
  logic [13:0]   adc_b;
  logic          trig;
  logic [AW-1:0] rd_addr;
  logic [15:0]   rd_a;
  logic [15:0]   rd_b;
  logic [31:0]   tick;
  logic [31:0]   t_last;
  int            n_chk;
  int            n_bad;

  trace_capture #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .adc_a(adc_a), .adc_b(adc_b),
    .trig(trig), .rd_addr(rd_addr), .rd_a(rd_a), .rd_b(rd_b)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  initial tick = '0;
  always @(negedge clk) tick <= tick + 1;
  assign adc_a = tick[13:0];
  assign adc_b = ~tick[13:0];

  function automatic logic [15:0] ex(logic [31:0] t, bit chb);
    logic [13:0] v;
    v = chb ? ~t[13:0] : t[13:0];
    return {{2{v[13]}}, v};
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk); #1;
    reg_we = 1'b1; reg_addr = a; reg_wdata = d; t_last = tick;
    @(posedge clk); #1;
    reg_we = 1'b0;
  endtask

  task automatic rd_reg(logic [3:0] a, output logic [31:0] v);
    @(negedge clk); #1;
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic rd_smp(int a, output logic [15:0] va, output logic [15:0] vb);
    @(negedge clk); #1;
    rd_addr = AW'(a);
    @(posedge clk); #1;
    va = rd_a; vb = rd_b;
  endtask

  task automatic pulse_trig(output logic [31:0] tt);
    @(negedge clk); #1;
    trig = 1'b1; tt = tick;
    @(posedge clk); #1;
    trig = 1'b0;
  endtask

  task automatic wait_done();
    logic [31:0] s;
    for (int i = 0; i < 400; i++) begin
      rd_reg(4'd8, s);
      if (s[2]) break;
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [31:0] t0;
    logic [31:0] tt;
    logic [15:0] a;
    logic [15:0] b;
    n_chk = 0; n_bad = 0;
    reg_we = 0; reg_addr = 0; reg_wdata = 0; trig = 0; rd_addr = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1 / R12 reset state
    rd_reg(4'd8, v); chk("R1 status after reset", v, 32'd0);
    rd_reg(4'd9, v); chk("R1 count after reset", v, 32'd0);
    // R2 identification words
    rd_reg(4'd0, v); chk("R2 id0", v, 32'hDEADBEEF);
    rd_reg(4'd1, v); chk("R2 id1", v, 32'hABADCAFE);
    rd_reg(4'd2, v); chk("R2 id2", v, 32'hBEEFBEEF);
    // R3 loopback
    rd_reg(4'd4, v); chk("R3 loop reset", v, 32'd0);
    wr(4'd3, 32'h1234_5678);
    rd_reg(4'd4, v); chk("R3 loop value", v, 32'h1234_5678);
    // R8 trigger while idle
    pulse_trig(tt);
    rd_reg(4'd8, v); chk("R8 trig idle", v, 32'd0);

    // Table: R4 R5 R6 R11 (each start after the first comes from done)
    for (int i = 0; i < 6; i++) begin
      wr(4'd5, VLEN[i]);
      wr(4'd7, 32'd1);
      t0 = t_last;
      wait_done();
      rd_reg(4'd9, v); chk("R6 R11 count", v, VEXP[i]);
      rd_reg(4'd8, v); chk("R12 done status", v, 32'd4);
      if (VEXP[i] != 0) begin
        rd_smp(0, a, b);
        chk("R4 first a", 32'(a), 32'(ex(t0 + 1, 1'b0)));
        chk("R5 first b sext", 32'(b), 32'(ex(t0 + 1, 1'b1)));
        rd_smp(int'(VEXP[i]) - 1, a, b);
        chk("R4 last a", 32'(a), 32'(ex(t0 + VEXP[i], 1'b0)));
      end
    end

    // R7 armed capture
    wr(4'd5, 32'd8);
    wr(4'd6, 32'd1);
    wr(4'd7, 32'd1);
    rd_reg(4'd8, v); chk("R7 R12 armed status", v, 32'd3);
    repeat (3) @(posedge clk);
    rd_reg(4'd9, v); chk("R7 no store while armed", v, 32'd0);
    pulse_trig(tt);
    wait_done();
    rd_reg(4'd9, v); chk("R7 count", v, 32'd8);
    rd_smp(0, a, b); chk("R7 first after trig", 32'(a), 32'(ex(tt + 1, 1'b0)));
    // R8 trigger while done
    pulse_trig(tt);
    rd_reg(4'd8, v); chk("R8 trig done", v, 32'd4);

    // R9 stop from armed
    wr(4'd7, 32'd1);
    wr(4'd7, 32'd2);
    rd_reg(4'd8, v); chk("R9 stop armed status", v, 32'd4);
    rd_reg(4'd9, v); chk("R9 stop armed count", v, 32'd0);

    // R9 stop during recording, R12 busy status
    wr(4'd6, 32'd0);
    wr(4'd5, 32'd40);
    wr(4'd7, 32'd1);
    repeat (4) @(posedge clk);
    rd_reg(4'd8, v); chk("R12 recording status", v, 32'd1);
    wr(4'd7, 32'd2);
    rd_reg(4'd8, v); chk("R9 stop rec status", v, 32'd4);
    rd_reg(4'd9, v); chk("R9 partial count", v, 32'd5);

    // R11 start ignored while busy
    wr(4'd7, 32'd1);
    t0 = t_last;
    repeat (2) @(posedge clk);
    wr(4'd7, 32'd1);
    wait_done();
    rd_reg(4'd9, v); chk("R11 busy start count", v, 32'd40);
    rd_smp(0, a, b); chk("R11 busy start data", 32'(a), 32'(ex(t0 + 1, 1'b0)));

    // R10 reset from done and mid recording
    wr(4'd7, 32'd3);
    rd_reg(4'd8, v); chk("R10 reset from done", v, 32'd0);
    wr(4'd7, 32'd1);
    repeat (3) @(posedge clk);
    wr(4'd7, 32'd3);
    rd_reg(4'd8, v); chk("R10 reset mid status", v, 32'd0);
    rd_reg(4'd9, v); chk("R10 reset mid count", v, 32'd0);

    summary();
    $finish;
  end

endmodule